// File: doc/BRIEF.md
# Boot Remap and Abort Status Unit

This block sits in front of the on-chip memories of a single-master 32-bit system bus. It splits the low 256 MB of the address map into 1 MB regions and turns each valid access into a one-hot target select plus a 20-bit offset within the region. Regions 1 to 4 always reach internal flash, core SRAM, backup SRAM and ROM. Region 0 is an alias. After reset it points at the boot flash. After a remap it points at the core SRAM, so software can install its own exception vectors at the bottom of the map.

An access to an undefined region, or one whose address is not a multiple of its transfer size, is refused. The block pulses an abort in the same cycle as the access and records the faulting address, the transfer size, the access kind and the cause. A small word-indexed register port toggles the remap state and reads back that state and the abort record.

Top module: `remap_abort_unit`

## Requirements
- R1: After reset the remap state is 0, and the remap control word (index 0), the abort address word (index 1) and the abort status word (index 2) all read as 0.
- R2: A write to index 0 with bit 0 set inverts the remap state, which reads back on bit 0 of index 0. A write with bit 0 clear leaves it unchanged.
- R3: A valid aligned access in 0x0000_0000..0x000F_FFFF selects the flash (`tgt_sel` = 4'b0001) while the remap state is 0, and the core SRAM (4'b0010) while it is 1.
- R4: Valid aligned accesses to 0x0010_0000, 0x0020_0000, 0x0030_0000 and 0x0040_0000 regions select 4'b0001 (flash), 4'b0010 (core SRAM), 4'b0100 (backup SRAM) and 4'b1000 (ROM), whatever the remap state. `tgt_off` equals address bits 19:0.
- R5: A valid access in 0x0050_0000..0x0FFF_FFFF raises `abort_o` in the same cycle and selects no target.
- R6: Size codes are 0 byte, 1 halfword, 2 word (3 aligns as word). A valid access inside 0x0000_0000..0x0FFF_FFFF that is not aligned to its size raises `abort_o` and selects no target.
- R7: On every abort, the abort address word is overwritten with the full 32-bit access address from the next cycle on.
- R8: On every abort, status bits [1:0] take the size code and bits [3:2] the kind code (0 data read, 1 data write, 2 fetch). Bit 8 (undefined) and bit 9 (misaligned) are set by their causes and accumulate across aborts.
- R9: Reading index 2 returns the current status and then clears bits 8 and 9. The size and kind fields are kept.
- R10: Valid accesses at 0x1000_0000 and above select nothing and raise no abort.
- R11: With `bus_valid` low there is no abort, no select and no change to the abort record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_addr | input | 32 | Access byte address |
| bus_size | input | 2 | Transfer size code |
| bus_kind | input | 2 | Access kind code |
| tgt_sel | output | 4 | One-hot memory select: flash, core SRAM, backup SRAM, ROM |
| tgt_off | output | 20 | Offset within the selected region |
| abort_o | output | 1 | Abort pulse, sent to every master |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_rd` is high |

## Verification
The hardest state to reach is the accumulation of both cause flags across separate aborts with no status read in between. Right next to it is a read that clears the flags while leaving the size and kind fields intact. Directed sequences produce an undefined-region abort followed by a misaligned one, then read twice. Random traffic mixes region boundaries, misaligned low address bits, out-of-space addresses, remap toggles and status reads at random points. The bench models the remap and the abort record itself.

// File: rtl/bra_pkg.sv
package bra_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [1:0] IDX_CTRL    = 2'd0;
  localparam logic [1:0] IDX_ABTADDR = 2'd1;
  localparam logic [1:0] IDX_ABTSTAT = 2'd2;

  localparam int unsigned ST_SIZE_LSB = 0;
  localparam int unsigned ST_KIND_LSB = 2;
  localparam int unsigned ST_UNDEF    = 8;
  localparam int unsigned ST_MISAL    = 9;

  function automatic logic is_misaligned(input logic [1:0] lo, input logic [1:0] sz);
    logic r;
    case (sz)
      SZ_BYTE: r = 1'b0;
      SZ_HALF: r = lo[0];
      default: r = |lo;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] pack_status(input logic [1:0] sz, input logic [1:0] kd,
                                              input logic undef, input logic misal);
    logic [31:0] w;
    w = '0;
    w[ST_SIZE_LSB +: 2] = sz;
    w[ST_KIND_LSB +: 2] = kd;
    w[ST_UNDEF] = undef;
    w[ST_MISAL] = misal;
    return w;
  endfunction

endpackage

// File: rtl/bra_addr_decode.sv
module bra_addr_decode #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REGION_BITS = 20,
  parameter int unsigned SPACE_BITS  = 28,
  parameter int unsigned N_DEFINED   = 5,
  localparam int unsigned N_TARGETS  = N_DEFINED - 1,
  localparam int unsigned RIDX_W     = SPACE_BITS - REGION_BITS,
  localparam int unsigned TIDX_W     = (N_TARGETS > 1) ? $clog2(N_TARGETS) : 1
) (
  input  logic                   valid,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             size,
  input  logic                   remap,
  output logic [N_TARGETS-1:0]   sel,
  output logic [REGION_BITS-1:0] offset,
  output logic                   ev_undef,
  output logic                   ev_misalign
);
  import bra_pkg::*;

  logic              in_space;
  logic [RIDX_W-1:0] ridx;
  logic              defined;
  logic              misal;
  logic [RIDX_W-1:0] ridx_m1;
  logic [TIDX_W-1:0] tidx;
  logic              hit;

  assign in_space = (addr[ADDR_W-1:SPACE_BITS] == '0);
  assign ridx     = addr[SPACE_BITS-1:REGION_BITS];
  assign defined  = (ridx < RIDX_W'(N_DEFINED));
  assign misal    = is_misaligned(addr[1:0], size);
  assign ridx_m1  = ridx - RIDX_W'(1);

  always_comb begin
    if (ridx == '0) tidx = remap ? TIDX_W'(1) : TIDX_W'(0);
    else            tidx = ridx_m1[TIDX_W-1:0];
  end

  assign ev_undef    = valid && in_space && !defined;
  assign ev_misalign = valid && in_space && misal;
  assign hit         = valid && in_space && defined && !misal;
  assign offset      = addr[REGION_BITS-1:0];

  for (genvar t = 0; t < N_TARGETS; t++) begin : g_sel
    assign sel[t] = hit && (tidx == TIDX_W'(t));
  end

endmodule

// File: rtl/bra_remap_ctl.sv
module bra_remap_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic remap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remap <= 1'b0;
    else if (toggle) remap <= ~remap;
  end
endmodule

// File: rtl/bra_abort_log.sv
module bra_abort_log #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_undef,
  input  logic              ev_misalign,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        kind,
  input  logic              clr,
  output logic [ADDR_W-1:0] abt_addr,
  output logic [1:0]        abt_size,
  output logic [1:0]        abt_kind,
  output logic              flag_undef,
  output logic              flag_mis
);
  logic ev_any;
  assign ev_any = ev_undef || ev_misalign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abt_addr <= '0;
      abt_size <= '0;
      abt_kind <= '0;
    end else if (ev_any) begin
      abt_addr <= addr;
      abt_size <= size;
      abt_kind <= kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_undef <= 1'b0;
      flag_mis   <= 1'b0;
    end else begin
      flag_undef <= ev_undef    || (flag_undef && !clr);
      flag_mis   <= ev_misalign || (flag_mis   && !clr);
    end
  end
endmodule

// File: rtl/remap_abort_unit.sv
module remap_abort_unit #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned REGION_BITS = 20,
  parameter int unsigned SPACE_BITS  = 28,
  parameter int unsigned N_DEFINED   = 5,
  localparam int unsigned N_TARGETS  = N_DEFINED - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [1:0]             bus_size,
  input  logic [1:0]             bus_kind,
  output logic [N_TARGETS-1:0]   tgt_sel,
  output logic [REGION_BITS-1:0] tgt_off,
  output logic                   abort_o,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [1:0]             reg_idx,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata
);
  import bra_pkg::*;

  logic              remap_q;
  logic              toggle_req;
  logic              ev_undef;
  logic              ev_misalign;
  logic              stat_clr;
  logic [ADDR_W-1:0] abt_addr_q;
  logic [1:0]        abt_size_q;
  logic [1:0]        abt_kind_q;
  logic              flag_undef_q;
  logic              flag_mis_q;

  bra_addr_decode #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS),
    .SPACE_BITS(SPACE_BITS), .N_DEFINED(N_DEFINED)
  ) u_dec (
    .valid(bus_valid), .addr(bus_addr), .size(bus_size), .remap(remap_q),
    .sel(tgt_sel), .offset(tgt_off), .ev_undef(ev_undef), .ev_misalign(ev_misalign)
  );

  assign toggle_req = reg_wr && (reg_idx == IDX_CTRL) && reg_wdata[0];
  assign stat_clr   = reg_rd && (reg_idx == IDX_ABTSTAT);
  assign abort_o    = ev_undef || ev_misalign;

  bra_remap_ctl u_remap (
    .clk(clk), .rst_n(rst_n), .toggle(toggle_req), .remap(remap_q)
  );

  bra_abort_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst_n(rst_n),
    .ev_undef(ev_undef), .ev_misalign(ev_misalign),
    .addr(bus_addr), .size(bus_size), .kind(bus_kind), .clr(stat_clr),
    .abt_addr(abt_addr_q), .abt_size(abt_size_q), .abt_kind(abt_kind_q),
    .flag_undef(flag_undef_q), .flag_mis(flag_mis_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_idx)
        IDX_CTRL:    reg_rdata = {31'b0, remap_q};
        IDX_ABTADDR: reg_rdata = 32'(abt_addr_q);
        IDX_ABTSTAT: reg_rdata = pack_status(abt_size_q, abt_kind_q, flag_undef_q, flag_mis_q);
        default:     reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/bra_checker.sv
module bra_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned N_TARGETS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 abort_o,
  input logic [N_TARGETS-1:0] tgt_sel,
  input logic                 ev_undef,
  input logic                 ev_misalign,
  input logic                 remap_q,
  input logic                 toggle_req,
  input logic [ADDR_W-1:0]    abt_addr_q,
  input logic                 flag_undef_q,
  input logic                 flag_mis_q,
  input logic                 stat_clr
);
  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_req |=> remap_q != $past(remap_q));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !toggle_req |=> remap_q == $past(remap_q));
  p_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[ADDR_W-1:20] == '0 && tgt_sel != '0) |-> (tgt_sel[1] == remap_q));
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  p_no_sel_on_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> tgt_sel == '0);
  p_addr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> abt_addr_q == $past(bus_addr));
  p_undef_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_undef |=> flag_undef_q);
  p_mis_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_misalign |=> flag_mis_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !abort_o) |=> (!flag_undef_q && !flag_mis_q));
  p_valid_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (!abort_o && tgt_sel == '0));
  p_record_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> abt_addr_q == $past(abt_addr_q));
endmodule

bind remap_abort_unit bra_checker #(.ADDR_W(ADDR_W), .N_TARGETS(N_TARGETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .abort_o(abort_o), .tgt_sel(tgt_sel), .ev_undef(ev_undef), .ev_misalign(ev_misalign),
  .remap_q(remap_q), .toggle_req(toggle_req), .abt_addr_q(abt_addr_q),
  .flag_undef_q(flag_undef_q), .flag_mis_q(flag_mis_q), .stat_clr(stat_clr)
);

// File: tb/remap_abort_unit_tb_top.sv
`timescale 1ns/1ps
module remap_abort_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [1:0]  bus_kind = '0;
  logic [3:0]  tgt_sel;
  logic [19:0] tgt_off;
  logic        abort_o;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic        m_remap = 1'b0;
  logic [31:0] m_addr = '0;
  logic [1:0]  m_size = '0;
  logic [1:0]  m_kind = '0;
  logic        m_undef = 1'b0;
  logic        m_mis = 1'b0;

  always #2.5 clk = ~clk;

  remap_abort_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_kind(bus_kind), .tgt_sel(tgt_sel), .tgt_off(tgt_off),
    .abort_o(abort_o), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic bit f_mis(input logic [31:0] a, input logic [1:0] s);
    int bytes;
    bytes = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    return (a % bytes) != 0;
  endfunction

  function automatic bit f_undef(input logic [31:0] a);
    return a >= 32'h0050_0000 && a < 32'h1000_0000;
  endfunction

  function automatic logic [3:0] f_sel(input logic [31:0] a, input logic [1:0] s, input logic rm);
    if (a >= 32'h0050_0000) return 4'b0000;
    if (f_mis(a, s)) return 4'b0000;
    if (a < 32'h0010_0000) return rm ? 4'b0010 : 4'b0001;
    return 4'b0001 << (a / 32'h0010_0000 - 1);
  endfunction

  function automatic logic [31:0] f_stat();
    return {22'b0, m_mis, m_undef, 4'b0, m_kind, m_size};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic v, input logic [31:0] a, input logic [1:0] s,
                        input logic [1:0] k, input string tag);
    bit ab_u, ab_m;
    bus_valid = v; bus_addr = a; bus_size = s; bus_kind = k;
    ab_u = v && f_undef(a);
    ab_m = v && (a < 32'h1000_0000) && f_mis(a, s);
    #1;
    check({tag, " abort"}, {31'b0, abort_o}, {31'b0, ab_u || ab_m});
    check({tag, " sel"}, {28'b0, tgt_sel}, {28'b0, v ? f_sel(a, s, m_remap) : 4'b0});
    if (v && f_sel(a, s, m_remap) != 0) check({tag, " off R4"}, {12'b0, tgt_off}, {12'b0, a[19:0]});
    @(posedge clk);
    if (ab_u || ab_m) begin
      m_addr = a; m_size = s; m_kind = k;
      m_undef = m_undef | ab_u; m_mis = m_mis | ab_m;
    end
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, input string tag);
    logic [31:0] exp;
    reg_rd = 1'b1; reg_idx = idx;
    exp = (idx == 2'd0) ? {31'b0, m_remap} : (idx == 2'd1) ? m_addr :
          (idx == 2'd2) ? f_stat() : 32'h0;
    #1;
    check(tag, reg_rdata, exp);
    @(posedge clk);
    if (idx == 2'd2) begin m_undef = 1'b0; m_mis = 1'b0; end
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk);
    if (idx == 2'd0 && d[0]) m_remap = ~m_remap;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1 ctrl");
    rd(2'd1, "R1 abtaddr");
    rd(2'd2, "R1 status");
    // R3 boot alias
    access(1, 32'h0000_0010, 2'd2, 2'd2, "R3 boot");
    // R2 toggle, write of 0 ignored
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, "R2 zero-write");
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, "R2 toggle-on");
    access(1, 32'h0000_0020, 2'd2, 2'd0, "R3 remapped");
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, "R2 toggle-off");
    // R4 region boundaries
    access(1, 32'h0010_0000, 2'd2, 2'd0, "R4 flash");
    access(1, 32'h002F_FFFE, 2'd1, 2'd1, "R4 csram");
    access(1, 32'h0030_0004, 2'd2, 2'd2, "R4 bsram");
    access(1, 32'h004F_FFFF, 2'd0, 2'd0, "R4 rom-top");
    // R10 out of space
    access(1, 32'h1000_0001, 2'd2, 2'd0, "R10 high");
    access(1, 32'hFFFF_FFFF, 2'd1, 2'd1, "R10 top");
    // R11 invalid ignored
    access(0, 32'h0060_0000, 2'd2, 2'd1, "R11 idle");
    rd(2'd1, "R11 abtaddr");
    // R5 undefined then R6 misaligned: R8 accumulate
    access(1, 32'h0050_0000, 2'd0, 2'd1, "R5 undef-low");
    rd(2'd1, "R7 addr");
    access(1, 32'h0020_0002, 2'd2, 2'd2, "R6 misal-word");
    rd(2'd1, "R7 overwrite");
    rd(2'd2, "R8 both flags");
    rd(2'd2, "R9 cleared keep fields");
    access(1, 32'h0FFF_FFFC, 2'd2, 2'd0, "R5 undef-top");
    access(1, 32'h0010_0001, 2'd1, 2'd1, "R6 misal-half");
    rd(2'd2, "R8 status");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2, 3, 4: a = (32'(pick) << 20) | ($urandom() & 32'h000F_FFFF);
        5, 6:          a = (32'($urandom_range(5, 255)) << 20) | ($urandom() & 32'h000F_FFFF);
        7:             a = $urandom() | 32'h1000_0000;
        default:       a = (32'($urandom_range(0, 4)) << 20) | 32'($urandom_range(0, 7));
      endcase
      if ($urandom_range(0, 15) == 0) wr(2'd0, $urandom());
      if ($urandom_range(0, 11) == 0) rd(2'($urandom_range(0, 3)), "R9 random read");
      access($urandom_range(0, 9) != 0, a, 2'($urandom_range(0, 2)),
             2'($urandom_range(0, 2)), "R5 random");
    end
    rd(2'd1, "R7 final");
    rd(2'd2, "R8 final");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule